// File: doc/BRIEF.md
# Serial Command Loader with Dot-Matrix Store

This block takes 8-bit command bytes over a three-wire serial link. The wires are a data line, a serial clock and an active-low load strobe. All three are sampled in the system clock domain. While the strobe is low, each rising serial-clock edge shifts one bit in, least significant bit first. When the strobe returns high, the upper three bits of the byte select what the byte does:

- write one row of dots for the current character,
- select the character to write,
- set the control word (brightness level, peak current, prescaler),
- clear the store.

The dot store holds 8 characters of 7 rows, each row 5 dots wide. A display scanner reads it through a combinational read port. After each character select, an internal row pointer starts at row 0. Every dot byte that follows goes to the next row. Software clear empties the store and raises a blank flag, which stays up until the next byte transfer begins. One specific control byte acts as power-down. The control word drives the brightness, peak-current and prescaler outputs. An asynchronous active-low reset returns every register to its initial value.

Top module: `dotcmd_loader`

## Requirements
- R1: A byte is taken as eight bits, each captured on a rising `sclk_i` edge while `load_ni` is low, first bit into bit 0. It is decoded when `load_ni` rises. The operation is selected by bits 7:5.
- R2: `sclk_i` edges while `load_ni` is high shift nothing and do not count toward the next byte, so a following eight-bit byte is still accepted.
- R3: A transfer that captures fewer or more than eight bits changes no state.
- R4: Operation 000 writes bits 4:0 to the current row of the current character. Reading that row on `rd_dots_o` returns the same value, with bit 4 the leftmost dot.
- R5: Operation 101 selects the character from bits 2:0 and sets the row pointer to row 0.
- R6: Successive dot bytes fill rows 0 to 6 in order. A character select arriving before row 6 is written leaves the rows not yet written in the old character unchanged.
- R7: A dot byte arriving after row 6 has been written goes to row 0 of the same character.
- R8: Operation 111 sets `bright_o` from bits 2:0, `full_peak_o` from bit 3 (1 = full current) and `prescale16_o` from bit 4 (1 = divide by 16).
- R9: Byte C0h zeroes every dot, selects character 0 row 0 and raises `blank_o`. `blank_o` falls when `load_ni` next falls. The control outputs are not changed.
- R10: Byte EFh raises `power_down_o`. Dot writes are still stored while it is high. Any other operation-111 byte clears it.
- R11: Bytes with operation 001, 010, 011 or 100, and operation-110 bytes other than C0h, change no state.
- R12: While `rst_ni` is low, all dots read 0, the character and row return to 0, `bright_o`=0, `full_peak_o`=1, `prescale16_o`=0, and `blank_o` and `power_down_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock, bits captured on its rising edge |
| load_ni | input | 1 | Active-low load strobe; rising edge decodes the byte |
| rd_char_i | input | 3 | Read-port character index |
| rd_row_i | input | 3 | Read-port row index (0 to 6) |
| rd_dots_o | output | 5 | Dots of the addressed row, bit 4 leftmost |
| bright_o | output | 3 | Brightness level from the control word |
| full_peak_o | output | 1 | 1 = full peak current, 0 = reduced |
| prescale16_o | output | 1 | 1 = divide multiplex clock by 16 |
| blank_o | output | 1 | Blank flag set by software clear |
| power_down_o | output | 1 | Power-down flag |

## Verification
The hardest cases to reach are those where nothing should happen. These are short or long transfers, serial-clock pulses with the strobe high, and undefined opcodes. Their only visible effect would be on where the next dot byte lands. After each such stimulus, the bench therefore sends a real dot byte and sweeps the whole store against its model. Any stray row advance or write shows up at a specific row. Row wrap and early character selects are reached by sending eight dot bytes, and only two, after a character select.

// File: rtl/dotcmd_pkg.sv
package dotcmd_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [2:0] OP_DOTS = 3'b000;
  localparam logic [2:0] OP_ADDR = 3'b101;
  localparam logic [2:0] OP_CTRL = 3'b111;

  localparam logic [7:0] BYTE_CLEAR = 8'hC0;
  localparam logic [7:0] BYTE_PWRDN = 8'hEF;

  typedef struct packed {
    logic       prescale16;
    logic       full_peak;
    logic [2:0] bright;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{prescale16: 1'b0, full_peak: 1'b1, bright: 3'd0};
endpackage

// File: rtl/dotcmd_sync.sv
module dotcmd_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dotcmd_shift.sv
module dotcmd_shift #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_s_i,
  input  logic            load_n_s_i,
  input  logic            data_s_i,
  output logic [BITS-1:0] byte_o,
  output logic            byte_vld_o,
  output logic            load_fall_o
);
  localparam int unsigned CNT_MAX = BITS + 1;
  localparam int unsigned CW = $clog2(CNT_MAX + 1);

  logic            sclk_q, load_q, vld_q;
  logic [BITS-1:0] sr_q;
  logic [CW-1:0]   cnt_q;
  logic            sclk_rise, load_rise;

  assign sclk_rise   = sclk_s_i & ~sclk_q;
  assign load_rise   = load_n_s_i & ~load_q;
  assign load_fall_o = ~load_n_s_i & load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      load_q <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      load_q <= load_n_s_i;
      vld_q  <= 1'b0;
      if (load_rise) begin
        vld_q <= (cnt_q == CW'(BITS));
        cnt_q <= '0;
      end else if (sclk_rise && !load_n_s_i) begin
        sr_q <= {data_s_i, sr_q[BITS-1:1]};
        if (cnt_q != CW'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign byte_o     = sr_q;
  assign byte_vld_o = vld_q;

  // R2
  load_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_n_s_i |=> $stable(sr_q));
  // R3
  short_byte_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_rise && cnt_q != CW'(BITS)) |=> !byte_vld_o);
endmodule

// File: rtl/dotcmd_ram.sv
module dotcmd_ram #(
  parameter int unsigned NCHAR = 8,
  parameter int unsigned NROW  = 7,
  parameter int unsigned COLS  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(NCHAR)-1:0] wchar_i,
  input  logic [$clog2(NROW)-1:0]  wrow_i,
  input  logic [COLS-1:0]          wdata_i,
  input  logic                     clr_i,
  input  logic [$clog2(NCHAR)-1:0] rchar_i,
  input  logic [$clog2(NROW)-1:0]  rrow_i,
  output logic [COLS-1:0]          rdata_o
);
  localparam int unsigned DEPTH = NCHAR * NROW;
  localparam int unsigned IW = $clog2(DEPTH);

  logic [COLS-1:0] mem_q [DEPTH];
  logic [DEPTH*COLS-1:0] flat;
  logic [IW-1:0] widx, ridx;

  assign widx = IW'(wchar_i) * IW'(NROW) + IW'(wrow_i);
  assign ridx = IW'(rchar_i) * IW'(NROW) + IW'(rrow_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (32'(rrow_i) < NROW && 32'(rchar_i) < NCHAR) rdata_o = mem_q[ridx];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*COLS +: COLS] = mem_q[g];
  end

  // R9
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flat == '0));
  // R4
  row_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> (mem_q[$past(widx)] == $past(wdata_i)));
endmodule

// File: rtl/dotcmd_loader.sv
module dotcmd_loader
  import dotcmd_pkg::*;
#(
  parameter int unsigned NCHAR = 8,
  parameter int unsigned NROW  = 7,
  parameter int unsigned COLS  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sdata_i,
  input  logic                     sclk_i,
  input  logic                     load_ni,
  input  logic [$clog2(NCHAR)-1:0] rd_char_i,
  input  logic [$clog2(NROW)-1:0]  rd_row_i,
  output logic [COLS-1:0]          rd_dots_o,
  output logic [2:0]               bright_o,
  output logic                     full_peak_o,
  output logic                     prescale16_o,
  output logic                     blank_o,
  output logic                     power_down_o
);
  localparam int unsigned CAW = $clog2(NCHAR);
  localparam int unsigned RAW = $clog2(NROW);
  localparam logic [RAW-1:0] ROW_LAST = RAW'(NROW - 1);

  logic [2:0]        sync_in, sync_out;
  logic              sclk_s, load_n_s, data_s;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_vld, load_fall;

  assign sync_in = {load_ni, sclk_i, sdata_i};

  dotcmd_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sync_in), .q_o(sync_out)
  );
  assign {load_n_s, sclk_s, data_s} = sync_out;

  dotcmd_shift #(.BITS(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .load_n_s_i (load_n_s),
    .data_s_i   (data_s),
    .byte_o     (rx_byte),
    .byte_vld_o (rx_vld),
    .load_fall_o(load_fall)
  );

  logic [2:0] op;
  logic       is_dots, is_addr, is_ctrl, is_clr, is_undef;
  assign op       = rx_byte[7:5];
  assign is_dots  = rx_vld && op == OP_DOTS;
  assign is_addr  = rx_vld && op == OP_ADDR;
  assign is_ctrl  = rx_vld && op == OP_CTRL;
  assign is_clr   = rx_vld && rx_byte == BYTE_CLEAR;
  assign is_undef = rx_vld && !is_dots && !is_addr && !is_ctrl && !is_clr;

  logic [CAW-1:0] char_q;
  logic [RAW-1:0] row_q;
  ctrl_t          ctrl_q;
  logic           pd_q, blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q  <= '0;
      row_q   <= '0;
      ctrl_q  <= CTRL_RST;
      pd_q    <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      if (load_fall) blank_q <= 1'b0;
      if (is_clr) begin
        char_q  <= '0;
        row_q   <= '0;
        blank_q <= 1'b1;
      end else if (is_addr) begin
        char_q <= rx_byte[CAW-1:0];
        row_q  <= '0;
      end else if (is_dots) begin
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else if (is_ctrl) begin
        ctrl_q <= ctrl_t'(rx_byte[4:0]);
        pd_q   <= (rx_byte == BYTE_PWRDN);
      end
    end
  end

  dotcmd_ram #(.NCHAR(NCHAR), .NROW(NROW), .COLS(COLS)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (is_dots),
    .wchar_i(char_q),
    .wrow_i (row_q),
    .wdata_i(rx_byte[COLS-1:0]),
    .clr_i  (is_clr),
    .rchar_i(rd_char_i),
    .rrow_i (rd_row_i),
    .rdata_o(rd_dots_o)
  );

  assign bright_o     = ctrl_q.bright;
  assign full_peak_o  = ctrl_q.full_peak;
  assign prescale16_o = ctrl_q.prescale16;
  assign blank_o      = blank_q;
  assign power_down_o = pd_q;

  // R5
  addr_row_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_addr |=> (row_q == '0));
  // R7
  row_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_dots && row_q == ROW_LAST) |=> (row_q == '0));
  // R9
  clear_keeps_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clr |=> ($stable(ctrl_q) && blank_q));
  // R10
  pd_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> (ctrl_q.bright == 3'd7));
  // R11
  undef_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_undef |=> ($stable(char_q) && $stable(row_q) && $stable(ctrl_q) && $stable(pd_q)));
endmodule

// File: tb/dotcmd_loader_bench.sv
`timescale 1ns/1ps
module dotcmd_loader_bench;
  logic clk = 0, rst_ni = 0, sdata = 0, sclk = 0, load_n = 1;
  logic [2:0] rd_char = 0, rd_row = 0;
  logic [4:0] rd_dots;
  logic [2:0] bright;
  logic full_peak, prescale16, blank, pd;

  int n_chk = 0, n_fail = 0;
  logic [4:0] m [8][7];
  logic [2:0] e_char, e_row;
  logic [4:0] e_ctl;
  logic e_pd, e_blank;

  always #10 clk = ~clk;

  dotcmd_loader u_dotcmd_loader (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .sclk_i(sclk), .load_ni(load_n),
    .rd_char_i(rd_char), .rd_row_i(rd_row), .rd_dots_o(rd_dots), .bright_o(bright),
    .full_peak_o(full_peak), .prescale16_o(prescale16), .blank_o(blank), .power_down_o(pd)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) for (int r = 0; r < 7; r++) m[c][r] = 0;
    e_char = 0; e_row = 0; e_ctl = 5'b01000; e_pd = 0; e_blank = 0;
  endtask

  task automatic model_byte(logic [7:0] b);
    if (b == 8'hC0) begin
      for (int c = 0; c < 8; c++) for (int r = 0; r < 7; r++) m[c][r] = 0;
      e_char = 0; e_row = 0; e_blank = 1;
    end else case (b[7:5])
      3'b000: begin m[e_char][e_row] = b[4:0]; e_row = (e_row == 6) ? 0 : e_row + 1; end
      3'b101: begin e_char = b[2:0]; e_row = 0; end
      3'b111: begin e_ctl = b[4:0]; e_pd = (b == 8'hEF); end
      default: ;
    endcase
  endtask

  task automatic load_begin();
    @(negedge clk) load_n = 0;
    tick(6);
    e_blank = 0;
  endtask

  task automatic shift_bits(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sdata = v[i];
      tick(3);
      @(negedge clk) sclk = 1;
      tick(3);
      @(negedge clk) sclk = 0;
    end
  endtask

  task automatic load_end();
    tick(3);
    @(negedge clk) load_n = 1;
    tick(8);
  endtask

  task automatic send(logic [7:0] b);
    load_begin(); shift_bits({8'h0, b}, 8); load_end();
    model_byte(b);
  endtask

  task automatic check_ctl(string req);
    @(negedge clk);
    chk(req, {prescale16, full_peak, bright}, e_ctl);
    chk(req, pd, e_pd);
    chk(req, blank, e_blank);
  endtask

  task automatic check_ram(string req);
    for (int c = 0; c < 8; c++) for (int r = 0; r < 7; r++) begin
      @(negedge clk); rd_char = c[2:0]; rd_row = r[2:0];
      #1 chk(req, rd_dots, m[c][r]);
    end
  endtask

  initial begin
    model_reset();
    tick(3);
    check_ctl("R12 reset ctrl");
    check_ram("R12 reset ram");
    @(negedge clk) rst_ni = 1;
    tick(4);

    // R1 R4 R5 R6: every character, every row, distinct patterns
    for (int c = 0; c < 8; c++) begin
      send(8'hA0 | c[7:0]);
      for (int r = 0; r < 7; r++) send({3'b000, 5'((c * 7 + r * 3 + 1) ^ (r << 2))});
    end
    check_ram("R4 R5 R6 fill");
    send(8'h01); send(8'h10);  // R1 asymmetric bit order, wrap onto rows 0,1 of char 7
    check_ram("R1 R7 wrap row");

    // R6 early reselect
    send(8'hA3); send(8'h15); send(8'h0A); send(8'hA4); send(8'h1F);
    check_ram("R6 early address");

    // R7 eight dot bytes after select
    send(8'hA2);
    for (int r = 0; r < 8; r++) send(8'h03 + r[7:0]);
    check_ram("R7 wrap");

    // R3 short and long transfers
    send(8'hA5);
    load_begin(); shift_bits(16'h001B, 7); load_end();
    load_begin(); shift_bits(16'h0011, 9); load_end();
    send(8'h0E);
    check_ram("R3 bad length");

    // R2 serial clocks with load high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) sdata = 1; tick(3);
      @(negedge clk) sclk = 1; tick(3);
      @(negedge clk) sclk = 0;
    end
    send(8'h19);
    check_ram("R2 load high");

    // R8 control sweep
    for (int v = 0; v < 32; v++) begin
      send(8'hE0 | v[7:0]);
      check_ctl("R8 ctrl");
    end

    // R11 undefined ops
    send(8'hE9);
    send(8'hA6);
    send(8'h2A); send(8'h55); send(8'h7F); send(8'h8C); send(8'hC5); send(8'hDF);
    check_ctl("R11 ctrl kept");
    send(8'h13);
    check_ram("R11 no row move");

    // R10 power-down
    send(8'hEF);
    check_ctl("R10 pd set");
    send(8'h1C);
    check_ram("R10 write in pd");
    send(8'hE3);
    check_ctl("R10 pd cleared");

    // R9 software clear
    send(8'hED);
    send(8'hC0);
    check_ctl("R9 blank set");
    check_ram("R9 cleared");
    load_begin();
    @(negedge clk) chk("R9 blank fall", blank, 0);
    shift_bits(16'h0016, 8); load_end();
    model_byte(8'h16);
    check_ram("R9 char0 row0");
    check_ctl("R9 ctrl kept");

    // R12 reset mid-run
    send(8'hF5);
    @(negedge clk) rst_ni = 0;
    model_reset();
    tick(2);
    check_ctl("R12 reset again");
    check_ram("R12 ram again");
    @(negedge clk) rst_ni = 1;
    tick(4);
    send(8'h07);
    check_ram("R12 row0 after reset");
    summary();
  end
endmodule